// File: doc/BRIEF.md
# SPI Flash User Command Bridge

This block gives software raw, byte-level access to a serial flash device for commands that are not plain data reads, for example reading the manufacturer and device identifier. Software sets a single enable bit to enter command mode. While that bit is set, chip select is held low across all byte accesses. Software can therefore build any multi-byte command sequence out of separate byte writes and byte reads on one data port.

A byte write on the data port shifts that byte out on the single MOSI line. A byte read shifts one byte in from MISO while MOSI is held high. The port does not acknowledge an access until all bits of the byte have been shifted. Clearing the enable bit ends the sequence: chip select is released once the byte in flight is complete. While command mode is active, or while chip select is still held, the normal memory-mapped read path is kept from starting a transaction.

To read the identifier, software sets the enable bit, writes the command byte 0x9E, and performs four reads. The four bytes come back most significant byte first, so software assembles them big-endian. It then clears the enable bit.

Top module: `spi_user_bridge`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 1 and `req_ready` is 0.
- R2: With `user_en` set and chip select released, a request is acknowledged by a one-cycle `req_ready` pulse. The edge that accepts the request is counted as the first cycle, and the pulse comes CS_LEAD + 16*CLK_HALF clock cycles after that edge. `spi_cs_n` goes low on the accepting edge.
- R3: A write request (`req_write`=1) shifts `req_wdata` out on `spi_mosi`, most significant bit first. The clock is SPI mode 0: SCLK idles low, MOSI changes only while SCLK is low, and both sides sample on the rising edge.
- R4: A read request (`req_write`=0) drives `spi_mosi` high for all eight bits. While `req_ready` is high, `rd_data` holds the eight MISO bits in arrival order, the first bit in bit 7.
- R5: When chip select is already held, a further request skips the lead-in delay and is acknowledged 16*CLK_HALF cycles after the accepting edge. `spi_cs_n` stays low between the bytes.
- R6: Clearing `user_en` while no byte is in flight raises `spi_cs_n` on the next clock edge.
- R7: A request made while `user_en` is 0 is acknowledged in the cycle after the accepting edge, returns `rd_data` = 0xFF, and produces no chip select or SCLK activity.
- R8: `mem_rd_go` follows `mem_rd_req` only while `user_en` is 0 and chip select is released. Otherwise it is 0.
- R9: `spi_sclk` is 0 whenever `spi_cs_n` is 1.
- R10: After command 0x9E is written, four reads return the device identifier bytes in big-endian order.
- R11: If `user_en` is cleared in the middle of a byte, the byte still completes with normal latency and chip select held. `spi_cs_n` rises two edges after the acknowledge pulse, provided no new request is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_en | input | 1 | Command mode enable bit |
| req_valid | input | 1 | Byte access request, held until `req_ready` |
| req_write | input | 1 | 1 = write byte, 0 = read byte |
| req_wdata | input | BYTE_W | Byte to transmit on a write |
| req_ready | output | 1 | One-cycle acknowledge after the byte has been shifted |
| rd_data | output | BYTE_W | Byte received from MISO, valid with `req_ready` |
| mem_rd_req | input | 1 | Memory-mapped read path wants to start a transaction |
| mem_rd_go | output | 1 | Permission for the memory-mapped read to start |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Each byte's acknowledge is due at a fixed cycle. The first byte of a sequence acknowledges CS_LEAD + 16*CLK_HALF edges after the accepting edge, a following byte 16*CLK_HALF edges after it, and a request while disabled one edge after it. The bench counts rising edges from the accepting edge and samples on the falling edge after each one. This gives an exact latency to compare against the value derived from the requirement. Chip-select release is expected exactly one edge after the enable bit drops while idle, and two edges after the acknowledge when the drop happened mid-byte. The read-gate output is combinational and is checked in the same cycle as its inputs change and again after the next edge. A small device model on the SPI pins captures MOSI on rising SCLK and presents MISO on falling SCLK, so bit order and data are checked at the pins.

// File: rtl/spi_ub_pkg.sv
package spi_ub_pkg;

   typedef enum logic [1:0] {
      UB_IDLE  = 2'd0,
      UB_LEAD  = 2'd1,
      UB_SHIFT = 2'd2,
      UB_ACK   = 2'd3
   } ub_state_t;

endpackage

// File: rtl/spi_ub_phase.sv
// Phase timer: ticks once every LIMIT cycles while run is held high.
module spi_ub_phase #(
   parameter int LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("spi_ub_phase: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign tick = run && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // Counter never passes the phase length (supports R2 timing)
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(LIMIT - 1));

endmodule

// File: rtl/spi_ub_shifter.sv
// Byte shift register: transmit side fills with ones, receive side collects MISO.
module spi_ub_shifter #(
   parameter int BYTE_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   input  logic              shift_en,
   input  logic              sample_en,
   input  logic              miso,
   output logic              mosi,
   output logic [BYTE_W-1:0] rx
);
   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("spi_ub_shifter: BYTE_W must be at least 2");
      end
   endgenerate

   logic [BYTE_W-1:0] tx;
   logic [BYTE_W-1:0] tx_next;
   logic [BYTE_W-1:0] rx_next;

   generate
      if (MSB_FIRST) begin : g_msb
         assign mosi    = tx[BYTE_W-1];
         assign tx_next = {tx[BYTE_W-2:0], 1'b1};
         assign rx_next = {rx[BYTE_W-2:0], miso};
      end else begin : g_lsb
         assign mosi    = tx[0];
         assign tx_next = {1'b1, tx[BYTE_W-1:1]};
         assign rx_next = {miso, rx[BYTE_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx <= '1;
         rx <= '1;
      end else if (load) begin
         tx <= load_val;
         rx <= '1;
      end else begin
         if (shift_en)  tx <= tx_next;
         if (sample_en) rx <= rx_next;
      end
   end

   // Shift and sample never coincide: they sit on opposite SCLK edges (R3)
   p_edges_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(shift_en && sample_en));

endmodule

// File: rtl/spi_ub_seq.sv
// Sequencer: chip-select ownership, lead-in, bit clocking, acknowledge.
module spi_ub_seq
   import spi_ub_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int CLK_HALF  = 2,
   parameter int CS_LEAD   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic user_en,
   input  logic req_valid,
   output logic req_ready,
   output logic load,
   output logic shift_en,
   output logic sample_en,
   output logic cs_act,
   output logic sclk
);
   localparam int BW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

   generate
      if (CLK_HALF < 1) begin : g_bad_half
         $error("spi_ub_seq: CLK_HALF must be at least 1");
      end
      if (CS_LEAD < 1) begin : g_bad_lead
         $error("spi_ub_seq: CS_LEAD must be at least 1");
      end
   endgenerate

   ub_state_t     state;
   logic [BW-1:0] bit_cnt;
   logic          lead_tick;
   logic          half_tick;

   spi_ub_phase #(.LIMIT(CS_LEAD)) i_lead (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state == UB_LEAD),
      .tick (lead_tick)
   );

   spi_ub_phase #(.LIMIT(CLK_HALF)) i_half (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state == UB_SHIFT),
      .tick (half_tick)
   );

   assign load      = (state == UB_IDLE) && req_valid;
   assign sample_en = half_tick && !sclk;
   assign shift_en  = half_tick && sclk;
   assign req_ready = (state == UB_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= UB_IDLE;
         cs_act  <= 1'b0;
         sclk    <= 1'b0;
         bit_cnt <= '0;
      end else begin
         unique case (state)
            UB_IDLE: begin
               if (!user_en) begin
                  cs_act <= 1'b0;
                  if (req_valid) state <= UB_ACK;
               end else if (req_valid) begin
                  if (cs_act) begin
                     state <= UB_SHIFT;
                  end else begin
                     cs_act <= 1'b1;
                     state  <= UB_LEAD;
                  end
               end
            end
            UB_LEAD: begin
               if (lead_tick) state <= UB_SHIFT;
            end
            UB_SHIFT: begin
               if (half_tick) begin
                  sclk <= !sclk;
                  if (sclk) begin
                     if (bit_cnt == BW'(BYTE_W - 1)) begin
                        bit_cnt <= '0;
                        state   <= UB_ACK;
                     end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
            end
            UB_ACK: begin
               state <= UB_IDLE;
            end
            default: state <= UB_IDLE;
         endcase
      end
   end

   // Chip select is never dropped while the enable bit stays set (R5)
   p_cs_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && user_en) |=> cs_act);

   // Serial clock idles low outside a chip-select window (R9)
   p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |-> !sclk);

   // Acknowledge is a single-cycle pulse (R2)
   p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   // With the bit cleared and chip select released, no clock is produced (R7)
   p_quiet_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!user_en && !cs_act) |=> !sclk);

   // SCLK returns low before the acknowledge (R3)
   p_ack_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !sclk);

endmodule

// File: rtl/spi_user_bridge.sv
module spi_user_bridge #(
   parameter int BYTE_W    = 8,
   parameter int CLK_HALF  = 2,
   parameter int CS_LEAD   = 1,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              user_en,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [BYTE_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              mem_rd_req,
   output logic              mem_rd_go,
   output logic              spi_sclk,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   logic              load;
   logic              shift_en;
   logic              sample_en;
   logic              cs_act;
   logic [BYTE_W-1:0] load_val;

   assign load_val  = (user_en && req_write) ? req_wdata : '1;
   assign spi_cs_n  = !cs_act;
   assign mem_rd_go = mem_rd_req && !user_en && !cs_act;

   spi_ub_seq #(
      .BYTE_W  (BYTE_W),
      .CLK_HALF(CLK_HALF),
      .CS_LEAD (CS_LEAD)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .user_en  (user_en),
      .req_valid(req_valid),
      .req_ready(req_ready),
      .load     (load),
      .shift_en (shift_en),
      .sample_en(sample_en),
      .cs_act   (cs_act),
      .sclk     (spi_sclk)
   );

   spi_ub_shifter #(
      .BYTE_W   (BYTE_W),
      .MSB_FIRST(MSB_FIRST)
   ) i_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .shift_en (shift_en),
      .sample_en(sample_en),
      .miso     (spi_miso),
      .mosi     (spi_mosi),
      .rx       (rd_data)
   );

   // MOSI holds steady through the high half of SCLK (R3)
   p_mosi_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

   // Memory reads are never granted while the bit is set (R8)
   p_mem_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (user_en || !spi_cs_n) |-> !mem_rd_go);

endmodule

// File: tb/test_spi_user_bridge.sv
module test_spi_user_bridge;
   localparam int W = 8;
   localparam int H = 3;
   localparam int L = 2;
   localparam int LAT_FIRST = 1 + L + 16 * H;
   localparam int LAT_NEXT  = 1 + 16 * H;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         user_en = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_write = 1'b0;
   logic [W-1:0] req_wdata = '0;
   logic         req_ready;
   logic [W-1:0] rd_data;
   logic         mem_rd_req = 1'b0;
   logic         mem_rd_go;
   logic         spi_sclk;
   logic         spi_cs_n;
   logic         spi_mosi;
   logic         spi_miso;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // Device model: presents MISO MSB first, captures MOSI on rising SCLK
   logic [W-1:0] dev_byte = 8'h00;
   logic [2:0]   dev_bit = 3'd0;
   logic [W-1:0] dev_rx = 8'h00;
   int           sclk_rises = 0;

   assign spi_miso = dev_byte[3'd7 - dev_bit];
   always @(negedge spi_sclk) dev_bit <= dev_bit + 3'd1;
   always @(posedge spi_sclk) begin
      dev_rx     <= {dev_rx[6:0], spi_mosi};
      sclk_rises <= sclk_rises + 1;
   end

   always #10 clk = !clk;

   spi_user_bridge #(
      .BYTE_W   (W),
      .CLK_HALF (H),
      .CS_LEAD  (L),
      .MSB_FIRST(1'b1)
   ) i_spi_user_bridge (
      .clk       (clk),
      .rst_n     (rst_n),
      .user_en   (user_en),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_wdata (req_wdata),
      .req_ready (req_ready),
      .rd_data   (rd_data),
      .mem_rd_req(mem_rd_req),
      .mem_rd_go (mem_rd_go),
      .spi_sclk  (spi_sclk),
      .spi_cs_n  (spi_cs_n),
      .spi_mosi  (spi_mosi),
      .spi_miso  (spi_miso)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // One byte access; returns received byte and latency in edges
   task automatic xfer(input bit wr, input logic [W-1:0] wd, input logic [W-1:0] dv,
                       output logic [W-1:0] rd, output int lat, output bit cs_low);
      @(negedge clk);
      dev_byte  = dv;
      req_valid = 1'b1;
      req_write = wr;
      req_wdata = wd;
      lat = 0;
      for (int i = 0; i < 2000; i++) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (req_ready) break;
      end
      rd     = rd_data;
      cs_low = !spi_cs_n;
      req_valid = 1'b0;
      @(posedge clk);
   endtask

   task automatic t_reset;
      chk(spi_cs_n == 1'b1, "R1 cs_n", int'(spi_cs_n), 1);
      chk(spi_sclk == 1'b0, "R1 sclk", int'(spi_sclk), 0);
      chk(spi_mosi == 1'b1, "R1 mosi", int'(spi_mosi), 1);
      chk(req_ready == 1'b0, "R1 ready", int'(req_ready), 0);
   endtask

   task automatic t_disabled;
      logic [W-1:0] rd; int lat; bit csl; int r0;
      r0 = sclk_rises;
      xfer(1'b1, 8'h5A, 8'h00, rd, lat, csl);
      chk(lat == 1, "R7 latency", lat, 1);
      chk(rd == 8'hFF, "R7 data", int'(rd), 'hFF);
      chk(!csl && spi_cs_n, "R7 cs idle", int'(spi_cs_n), 1);
      chk(sclk_rises == r0, "R7 no sclk", sclk_rises, r0);
   endtask

   task automatic t_write_then_read;
      logic [W-1:0] rd; int lat; bit csl;
      @(negedge clk); user_en = 1'b1;
      xfer(1'b1, 8'hA6, 8'h3C, rd, lat, csl);
      chk(lat == LAT_FIRST, "R2 first latency", lat, LAT_FIRST);
      chk(csl, "R2 cs low", int'(csl), 1);
      chk(dev_rx == 8'hA6, "R3 msb-first write", int'(dev_rx), 'hA6);
      chk(rd == 8'h3C, "R3 full-duplex capture", int'(rd), 'h3C);
      xfer(1'b0, 8'h00, 8'h81, rd, lat, csl);
      chk(lat == LAT_NEXT, "R5 next latency", lat, LAT_NEXT);
      chk(csl && !spi_cs_n, "R5 cs held", int'(spi_cs_n), 0);
      chk(dev_rx == 8'hFF, "R4 mosi ones", int'(dev_rx), 'hFF);
      chk(rd == 8'h81, "R4 read data", int'(rd), 'h81);
      chk(spi_sclk == 1'b0, "R9 sclk low idle", int'(spi_sclk), 0);
      // release
      @(negedge clk);
      user_en = 1'b0;
      chk(spi_cs_n == 1'b0, "R6 cs before edge", int'(spi_cs_n), 0);
      @(negedge clk);
      chk(spi_cs_n == 1'b1, "R6 cs released", int'(spi_cs_n), 1);
      chk(spi_sclk == 1'b0, "R9 sclk low released", int'(spi_sclk), 0);
   endtask

   task automatic t_id;
      logic [W-1:0] rd; int lat; bit csl;
      logic [31:0] id;
      logic [31:0] exp_id;
      exp_id = 32'h20BA_1910;
      id = '0;
      @(negedge clk); user_en = 1'b1;
      xfer(1'b1, 8'h9E, 8'hFF, rd, lat, csl);
      chk(dev_rx == 8'h9E, "R10 command", int'(dev_rx), 'h9E);
      for (int k = 0; k < 4; k++) begin
         xfer(1'b0, 8'h00, exp_id[31 - 8*k -: 8], rd, lat, csl);
         id = {id[23:0], rd};
         chk(csl, "R10 cs held", int'(csl), 1);
      end
      chk(id == exp_id, "R10 id big-endian", int'(id), int'(exp_id));
      @(negedge clk); user_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_mem_gate;
      @(negedge clk);
      mem_rd_req = 1'b1;
      #1;
      chk(mem_rd_go == 1'b1, "R8 go when off", int'(mem_rd_go), 1);
      user_en = 1'b1;
      #1;
      chk(mem_rd_go == 1'b0, "R8 blocked by bit", int'(mem_rd_go), 0);
      mem_rd_req = 1'b0;
   endtask

   task automatic t_drop_mid;
      int lat;
      logic [W-1:0] rd;
      // user_en already set, cs released: start a byte, drop the bit mid-way
      @(negedge clk);
      dev_byte = 8'h96; req_valid = 1'b1; req_write = 1'b0;
      lat = 0;
      for (int i = 0; i < 2000; i++) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (lat == L + 4) begin
            user_en = 1'b0;
            mem_rd_req = 1'b1;
            #1;
            chk(mem_rd_go == 1'b0, "R8 blocked by cs", int'(mem_rd_go), 0);
         end
         if (req_ready) break;
      end
      rd = rd_data;
      chk(lat == LAT_FIRST, "R11 latency", lat, LAT_FIRST);
      chk(rd == 8'h96, "R11 data", int'(rd), 'h96);
      chk(spi_cs_n == 1'b0, "R11 cs at ack", int'(spi_cs_n), 0);
      req_valid = 1'b0;
      @(negedge clk);
      chk(spi_cs_n == 1'b0, "R11 cs one edge", int'(spi_cs_n), 0);
      @(negedge clk);
      chk(spi_cs_n == 1'b1, "R11 cs released", int'(spi_cs_n), 1);
      chk(mem_rd_go == 1'b1, "R8 go after release", int'(mem_rd_go), 1);
      mem_rd_req = 1'b0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_write_then_read();
      t_id();
      t_mem_gate();
      t_drop_mid();
      repeat (4) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      finish_run();
   end

endmodule